// File: doc/BRIEF.md
# Lamp Ignition Pulse Timer

This block sequences the enable of an external pulse-ignition circuit while a discharge lamp is being started. A slow timer tick from an outside oscillator is prescaled into coarse time units. Each burst frame opens with an enable window and is followed by a longer quiet window. The pattern repeats until the lamp strikes or an absolute attempt limit runs out. When the limit runs out, a one-cycle no-strike fault pulse is issued, and an external latch holds it.

A lamp-voltage comparator that is still high means the lamp has not struck yet. The comparator is asynchronous, so the block synchronises it first; when it drops, bursting stops for good. The full-bridge dead-time flag blanks the enable output directly, so no ignition pulse can occur while the bridge mid-points are floating. A two-bit mode input gates the block's activity, and the under-voltage lockout mode clears all of its state.

With default parameters a tick of about 0.67 s is divided by 32 into units of about 21 s. Each frame has one enable unit and three quiet units, which gives 128 ticks per frame. The attempt limit is 37 units, about 787 s.

Top module: `ign_pulse_timer`

## Requirements
- R1: After reset, `ignEn` and `noStrikeFault` are low.
- R2: Mode encoding: 0 = under-voltage lockout, 1 = start-up, 2 = running, 3 = fault. Time counts only in start-up mode, while no strike is latched, the attempt limit is not spent and the synchronised comparator is high. Each `DIV_TICKS` counted `tickIn` strobes form one unit, and a frame is `ON_UNITS + OFF_UNITS` units long. `ignEn` is high during the first `ON_UNITS` units of each frame and low for the rest. The first frame begins when start-up mode is first entered.
- R3: On the clock edge that samples the `tickIn` strobe completing unit number `LIMIT_UNITS`, `noStrikeFault` goes high for exactly one cycle. From then on, `ignEn` stays low until lockout mode is applied.
- R4: While `deadTime` is high, `ignEn` is low in the same cycle. The burst schedule keeps counting, and the enable returns when `deadTime` falls if the schedule is still in an enable unit.
- R5: `lampHigh` passes through a two-flop synchroniser. Two edges after it falls in start-up mode, a strike is latched. From the following cycle `ignEn` is low, counting stops and no fault is raised until lockout mode is applied.
- R6: Lockout mode clears the prescaler, the frame position, the attempt count, the strike latch and the spent-limit state. A later entry into start-up mode begins a fresh first frame with the enable high.
- R7: In running and fault modes, `ignEn` is low and counting is frozen. A return to start-up mode resumes from the position where counting stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickIn | input | 1 | One-cycle strobe per slow oscillator period |
| lampHigh | input | 1 | Asynchronous comparator: high while lamp voltage is above the over-voltage fraction |
| deadTime | input | 1 | Full-bridge dead-time flag |
| mode | input | 2 | Controller mode (0 lockout, 1 start-up, 2 running, 3 fault) |
| ignEn | output | 1 | Ignition circuit enable |
| noStrikeFault | output | 1 | One-cycle pulse when the attempt limit is spent without a strike |

## Verification
The bound checker watches every cycle for the following:
- dead-time blanking of the enable;
- the enable being silent outside start-up mode;
- the single-cycle width of the fault pulse, and that the pulse only follows start-up mode;
- the enable staying silent after a fault pulse until lockout.

Other behaviour only the bench's scenarios can show, by comparing against a behavioural model on every clock. This covers the exact on/off unit schedule and the unit on which the limit expires. It also covers the synchroniser latency of a strike, the fresh frame after lockout, and that frozen modes resume where counting stopped.

// File: rtl/ign_pkg.sv
package ign_pkg;

  typedef enum logic [1:0] {
    MODE_UVLO  = 2'd0,
    MODE_START = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_FAULT = 2'd3
  } ignMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // wipe all timing state (lockout)
    logic run;    // counting permitted this cycle
  } ctlStrobe_t;

endpackage

// File: rtl/ign_timer_dp.sv
module ign_timer_dp
  import ign_pkg::*;
#(
  parameter int DIV_TICKS   = 32,
  parameter int ON_UNITS    = 1,
  parameter int OFF_UNITS   = 3,
  parameter int LIMIT_UNITS = 37,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickIn,
  input  logic       lampHigh,
  input  ctlStrobe_t strobe,
  output logic       lampSync,
  output logic       unitWrap,
  output logic       lastUnit,
  output logic       phaseOn
);

  localparam int FRAME_UNITS = ON_UNITS + OFF_UNITS;
  localparam int PRE_W       = (DIV_TICKS > 1) ? $clog2(DIV_TICKS) : 1;
  localparam int FRAME_W     = (FRAME_UNITS > 1) ? $clog2(FRAME_UNITS) : 1;
  localparam int LIMIT_W     = $clog2(LIMIT_UNITS + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [PRE_W-1:0]       preCnt;
  logic [FRAME_W-1:0]     framePos;
  logic [LIMIT_W-1:0]     attemptCnt;

  // Synchroniser for the asynchronous comparator; reset to "not struck"
  always_ff @(posedge clk) begin
    if (rst) syncChain <= '1;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], lampHigh};
  end
  assign lampSync = syncChain[SYNC_STAGES-1];

  assign unitWrap = strobe.run && tickIn && (preCnt == PRE_W'(DIV_TICKS - 1));
  assign lastUnit = (attemptCnt == LIMIT_W'(LIMIT_UNITS - 1));
  assign phaseOn  = (framePos < FRAME_W'(ON_UNITS));

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      preCnt     <= '0;
      framePos   <= '0;
      attemptCnt <= '0;
    end else if (strobe.run && tickIn) begin
      if (unitWrap) begin
        preCnt   <= '0;
        framePos <= (framePos == FRAME_W'(FRAME_UNITS - 1)) ? '0 : framePos + 1'b1;
        if (attemptCnt != LIMIT_W'(LIMIT_UNITS))
          attemptCnt <= attemptCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ign_timer_ctl.sv
module ign_timer_ctl
  import ign_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       deadTime,
  input  logic       lampSync,
  input  logic       unitWrap,
  input  logic       lastUnit,
  input  logic       phaseOn,
  output ctlStrobe_t strobe,
  output logic       ignEn,
  output logic       faultPulse
);

  logic struckQ;
  logic spentQ;
  logic inStart;

  assign inStart = (ignMode_e'(mode) == MODE_START);

  always_comb begin
    strobe.clear = (ignMode_e'(mode) == MODE_UVLO);
    strobe.run   = inStart && !struckQ && !spentQ && lampSync;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      struckQ    <= 1'b0;
      spentQ     <= 1'b0;
      faultPulse <= 1'b0;
    end else begin
      faultPulse <= unitWrap && lastUnit;
      if (unitWrap && lastUnit) spentQ <= 1'b1;
      if (inStart && !lampSync && !spentQ) struckQ <= 1'b1;
    end
  end

  assign ignEn = inStart && !struckQ && !spentQ && phaseOn && !deadTime;

endmodule

// File: rtl/ign_pulse_timer.sv
module ign_pulse_timer
  import ign_pkg::*;
#(
  parameter int DIV_TICKS   = 32,
  parameter int ON_UNITS    = 1,
  parameter int OFF_UNITS   = 3,
  parameter int LIMIT_UNITS = 37
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickIn,
  input  logic       lampHigh,
  input  logic       deadTime,
  input  logic [1:0] mode,
  output logic       ignEn,
  output logic       noStrikeFault
);

  ctlStrobe_t strobe;
  logic lampSync;
  logic unitWrap;
  logic lastUnit;
  logic phaseOn;

  ign_timer_dp #(
    .DIV_TICKS  (DIV_TICKS),
    .ON_UNITS   (ON_UNITS),
    .OFF_UNITS  (OFF_UNITS),
    .LIMIT_UNITS(LIMIT_UNITS),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .tickIn  (tickIn),
    .lampHigh(lampHigh),
    .strobe  (strobe),
    .lampSync(lampSync),
    .unitWrap(unitWrap),
    .lastUnit(lastUnit),
    .phaseOn (phaseOn)
  );

  ign_timer_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .deadTime  (deadTime),
    .lampSync  (lampSync),
    .unitWrap  (unitWrap),
    .lastUnit  (lastUnit),
    .phaseOn   (phaseOn),
    .strobe    (strobe),
    .ignEn     (ignEn),
    .faultPulse(noStrikeFault)
  );

endmodule

// File: rtl/ign_timer_chk.sv
module ign_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       deadTime,
  input logic [1:0] mode,
  input logic       ignEn,
  input logic       noStrikeFault
);

  logic faultSeen;

  always_ff @(posedge clk) begin
    if (rst || mode == 2'd0) faultSeen <= 1'b0;
    else if (noStrikeFault)  faultSeen <= 1'b1;
  end

  // R4: dead-time blanks the enable
  a_r4_deadtime_blank: assert property (@(posedge clk) disable iff (rst)
    deadTime |-> !ignEn);

  // R7: no enable outside start-up mode
  a_r7_mode_gate: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd1) |-> !ignEn);

  // R3: fault pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    noStrikeFault |=> !noStrikeFault);

  // R3: fault pulse only follows a start-up cycle
  a_r3_fault_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(noStrikeFault) |-> $past(mode) == 2'd1);

  // R3: silence after the fault until lockout
  a_r3_quiet_after_fault: assert property (@(posedge clk) disable iff (rst)
    faultSeen |-> !ignEn);

endmodule

bind ign_pulse_timer ign_timer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .deadTime     (deadTime),
  .mode         (mode),
  .ignEn        (ignEn),
  .noStrikeFault(noStrikeFault)
);

// File: tb/tb_ign_pulse_timer.sv
module tb_ign_pulse_timer;

  localparam int DIV   = 4;
  localparam int ONU   = 2;
  localparam int OFFU  = 3;
  localparam int LIMIT = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       tickIn = 1'b0;
  logic       lampHigh = 1'b1;
  logic       deadTime = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       ignEn;
  logic       noStrikeFault;

  ign_pulse_timer #(
    .DIV_TICKS(DIV), .ON_UNITS(ONU), .OFF_UNITS(OFFU), .LIMIT_UNITS(LIMIT)
  ) dut (
    .clk(clk), .rst(rst), .tickIn(tickIn), .lampHigh(lampHigh),
    .deadTime(deadTime), .mode(mode), .ignEn(ignEn), .noStrikeFault(noStrikeFault)
  );

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit checking = 0;
  bit tickEn = 0;
  bit dtEn = 0;
  int cyc = 0;
  int faultCount = 0;

  // behavioural reference state
  int mS1, mS2, mPre, mUnit, mTotal, mStruck, mSpent, mFault;

  always @(posedge clk) begin
    int run;
    int wrap;
    cyc <= cyc + 1;
    if (rst) begin
      mS1 = 1; mS2 = 1; mPre = 0; mUnit = 0; mTotal = 0;
      mStruck = 0; mSpent = 0; mFault = 0;
    end else begin
      run  = (mode == 2'd1 && !mStruck && !mSpent && mS2 == 1) ? 1 : 0;
      wrap = (run == 1 && tickIn && mPre == DIV - 1) ? 1 : 0;
      if (mode == 2'd0) begin
        mPre = 0; mUnit = 0; mTotal = 0; mStruck = 0; mSpent = 0; mFault = 0;
      end else begin
        mFault = (wrap == 1 && mTotal == LIMIT - 1) ? 1 : 0;
        if (mode == 2'd1 && mS2 == 0 && !mSpent) mStruck = 1;
        if (run == 1 && tickIn) begin
          if (wrap == 1) begin
            mPre = 0;
            mUnit = (mUnit + 1) % (ONU + OFFU);
            if (mTotal == LIMIT - 1) mSpent = 1;
            if (mTotal < LIMIT) mTotal = mTotal + 1;
          end else begin
            mPre = mPre + 1;
          end
        end
      end
      mS2 = mS1;
      mS1 = lampHigh ? 1 : 0;
    end
  end

  // stimulus for tick and dead-time, driven after the edge
  always @(posedge clk) begin
    #1;
    tickIn   = tickEn && (cyc % 3 == 0);
    deadTime = dtEn && (cyc % 17 < 3);
  end

  always @(negedge clk) begin
    logic expEn;
    if (checking) begin
      expEn = (mode == 2'd1 && !mStruck && !mSpent && mUnit < ONU && !deadTime);
      compared++;
      if (ignEn !== expEn || noStrikeFault !== mFault[0]) begin
        mismatched++;
        $display("FAIL %s: ignEn=%b fault=%b expected ignEn=%b fault=%b at cycle %0d",
                 curReq, ignEn, noStrikeFault, expEn, mFault[0], cyc);
      end
      if (noStrikeFault === 1'b1) faultCount++;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic checkVal(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    waitCyc(1);
    checking = 1;
    waitCyc(2);
    curReq = "R1";
    checkVal("R1", int'(ignEn), 0);
    checkVal("R1", int'(noStrikeFault), 0);
    rst = 0;
    waitCyc(2);

    // R2: burst schedule from first entry into start-up
    curReq = "R2";
    mode = 2'd1; tickEn = 1;
    waitCyc(1);
    checkVal("R2", int'(ignEn), 1);
    waitCyc(60);

    // R4: dead-time blanking while schedule runs
    curReq = "R4";
    dtEn = 1;
    waitCyc(60);
    dtEn = 0;

    // R3: attempt limit expires without a strike
    curReq = "R3";
    waitCyc(100);
    checkVal("R3", faultCount, 1);
    checkVal("R3", int'(ignEn), 0);

    // R6: lockout clears, fresh frame after re-entry
    curReq = "R6";
    mode = 2'd0;
    waitCyc(3);
    mode = 2'd1;
    waitCyc(2);
    checkVal("R6", int'(ignEn), 1);
    waitCyc(20);

    // R5: strike stops bursting, no fault afterwards
    curReq = "R5";
    lampHigh = 0;
    waitCyc(6);
    checkVal("R5", int'(ignEn), 0);
    lampHigh = 1;
    waitCyc(180);
    checkVal("R5", faultCount, 1);

    // R7: running and fault modes freeze counting
    curReq = "R7";
    mode = 2'd0;
    waitCyc(2);
    mode = 2'd1;
    waitCyc(20);
    mode = 2'd2;
    waitCyc(30);
    checkVal("R7", int'(ignEn), 0);
    mode = 2'd3;
    waitCyc(10);
    mode = 2'd1;
    waitCyc(60);

    checking = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule